// File: doc/BRIEF.md
# Four-Channel I/Q Sample Output Port

This block collects complex samples from four independent producer channels and hands them, one word at a time, to a single 16-bit output bus. Each channel owns one holding slot. A producer writes a slot with a one-cycle `in_valid` strobe. A newer sample replaces an unread one in the same slot, and it never touches another channel's slot. When more than one slot is full, a fixed-priority selector serves the lowest-numbered channel first.

The output is a valid/ready stream. `out_valid` rises as soon as any slot holds a sample. A word is consumed on a rising clock edge where both `out_valid` and `out_ready` are high. Back-pressure rules:
- While `out_ready` is low, `out_valid` never falls.
- While the first word of a sample waits, the word on the bus may still change, because a newer sample or a higher-priority channel can arrive.
- Once the I word of a pair has been taken, the matching Q word is fixed until it is taken.

The input side has no back-pressure: each producer writes its slot whenever it has a new sample.

The `fmt8` pin selects one of two packings:
- Wide mode: a full 16-bit I word goes out, then a full 16-bit Q word.
- Packed mode: one word carries the upper byte of I and the upper byte of Q.

`out_iq` marks I-bearing words, and `out_ch` names the source channel.

Top module: `iq_out_port`

## Requirements
- R1: `out_valid` is low after reset and is high exactly when at least one channel slot holds an unread sample.
- R2: A word is consumed only on a rising clock edge with `out_valid` and `out_ready` both high. While `out_ready` is low, the sample on the bus is not consumed and `out_valid` stays high.
- R3: With `fmt8`=0, a sample goes out as two words: first I[15:0] with `out_iq`=1, then, after the I word is consumed, Q[15:0] with `out_iq`=0.
- R4: With `fmt8`=1, a sample goes out as one word, `out_data`[15:8]=I[15:8] and `out_data`[7:0]=Q[15:8], with `out_iq`=1.
- R5: With `fmt8`=1, `out_iq` stays high on every cycle while channels are drained back to back, and falls only when no slot is full.
- R6: `out_ch` carries the binary number (0 to 3) of the channel whose data is on `out_data`.
- R7: When several slots are full, the channel with the lowest number goes first. Once a wide-mode I word is consumed, the Q word of that same channel follows before any other channel is served.
- R8: A new sample for channel c replaces the unread sample in slot c only. The samples waiting in other slots are unchanged.
- R9: A sample that arrives for a channel whose wide-mode pair is in progress is held back. It does not alter the Q word still to be sent, and it enters the slot when that Q word is consumed.
- R10: A slot empties when its last word is consumed, unless a new sample for that channel arrives in the same cycle. In that case the new sample stays pending.
- R11: While `out_valid` is low, `out_data`, `out_iq` and `out_ch` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt8 | input | 1 | 0: two full-width words per sample, 1: one packed byte-pair word |
| in_valid | input | 4 | One strobe per channel, loads that channel's slot |
| in_i | input | 64 | I samples, channel c in bits [16c+15:16c] |
| in_q | input | 64 | Q samples, channel c in bits [16c+15:16c] |
| out_valid | output | 1 | A word is offered on `out_data` |
| out_ready | input | 1 | Consumer accepts the offered word |
| out_data | output | 16 | Output word |
| out_iq | output | 1 | High on words that carry I data |
| out_ch | output | 2 | Source channel of the current word |

## Verification
Directed patterns come first:
- Simultaneous arrivals on several channels separate priority order from arrival order.
- A second write to a waiting slot separates per-channel overwrite from cross-channel corruption.
- A write landing between the I and Q words of a pair reveals any pair splitting.
- A write landing on the very cycle a slot drains separates "stays full" from "empties".

A long random phase then varies the arrival strobes, the consumer's readiness and the packing mode, and a behavioural model checks every output on every cycle. This exposes stall-handling and mode-switch errors that the directed cases cannot reach.

// File: rtl/iq_port_pkg.sv
package iq_port_pkg;
  localparam int IQ_W   = 16;
  localparam int HALF_W = IQ_W / 2;

  typedef struct packed {
    logic [IQ_W-1:0] i;
    logic [IQ_W-1:0] q;
  } sample_t;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } phase_e;
endpackage

// File: rtl/iq_slot.sv
module iq_slot
  import iq_port_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_v,
  input  sample_t in_s,
  input  logic    lock,
  input  logic    done,
  output logic    vld,
  output sample_t cur
);
  logic    pv;
  sample_t pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      cur  <= '0;
      pv   <= 1'b0;
      pend <= '0;
    end else begin
      if (in_v && !lock) begin
        cur <= in_s;
        vld <= 1'b1;
      end else if (done && pv) begin
        cur <= pend;
        vld <= 1'b1;
      end else if (done) begin
        vld <= 1'b0;
      end

      if (in_v && lock) begin
        pv   <= 1'b1;
        pend <= in_s;
      end else if (done) begin
        pv <= 1'b0;
      end
    end
  end

  AST_NO_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && in_v) |=> $stable(cur)); // R9
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !in_v && !pv) |=> !vld); // R10
endmodule

// File: rtl/iq_prio_sel.sv
module iq_prio_sel #(
  parameter  int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pend_v,
  output logic           any,
  output logic [CHW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (pend_v[c]) begin
        any = 1'b1;
        idx = CHW'(c);
      end
    end
  end

  AST_GRANT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> pend_v[idx]); // R7
  AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((pend_v & ((NCH'(1) << idx) - NCH'(1))) == '0)); // R7
endmodule

// File: rtl/iq_out_seq.sv
module iq_out_seq
  import iq_port_pkg::*;
#(
  parameter  int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fmt8,
  input  logic            any,
  input  logic [CHW-1:0]  idx,
  input  sample_t         smp [NCH],
  input  logic            out_ready,
  output logic            out_valid,
  output logic [IQ_W-1:0] out_data,
  output logic            out_iq,
  output logic [CHW-1:0]  out_ch,
  output logic [NCH-1:0]  lock,
  output logic [NCH-1:0]  done
);
  phase_e         phase;
  logic [CHW-1:0] hch;
  logic [CHW-1:0] sel;
  logic           fire;
  logic           last_word;
  logic           hold_pair;
  sample_t        cur;

  assign sel       = (phase == PH_SECOND) ? hch : idx;
  assign out_valid = any;
  assign fire      = any && out_ready;
  assign last_word = fire && ((phase == PH_SECOND) || fmt8);
  assign hold_pair = ((phase == PH_SECOND) && !fire) ||
                     ((phase == PH_FIRST) && fire && !fmt8);
  assign out_iq    = any && (phase == PH_FIRST);
  assign out_ch    = any ? sel : '0;

  always_comb begin
    cur = smp[sel];
    if (!any)
      out_data = '0;
    else if (phase == PH_SECOND)
      out_data = cur.q;
    else if (fmt8)
      out_data = {cur.i[IQ_W-1 -: HALF_W], cur.q[IQ_W-1 -: HALF_W]};
    else
      out_data = cur.i;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ctl
    assign done[g] = last_word && (sel == CHW'(g));
    assign lock[g] = hold_pair && (sel == CHW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_FIRST;
      hch   <= '0;
    end else if (phase == PH_FIRST) begin
      if (fire && !fmt8) begin
        phase <= PH_SECOND;
        hch   <= idx;
      end
    end else if (fire) begin
      phase <= PH_FIRST;
    end
  end

  AST_Q_FOLLOWS_I: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && phase == PH_FIRST && !fmt8) |=> (out_valid && !out_iq)); // R3
  AST_PAIR_SAME_CH: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && phase == PH_FIRST && !fmt8) |=> $stable(out_ch)); // R7
  AST_PACKED_IQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt8 && phase == PH_FIRST && out_valid) |-> out_iq); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0 && !out_iq && out_ch == '0)); // R11
endmodule

// File: rtl/iq_out_port.sv
module iq_out_port
  import iq_port_pkg::*;
#(
  parameter  int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fmt8,
  input  logic [NCH-1:0]      in_valid,
  input  logic [NCH*IQ_W-1:0] in_i,
  input  logic [NCH*IQ_W-1:0] in_q,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [IQ_W-1:0]     out_data,
  output logic                out_iq,
  output logic [CHW-1:0]      out_ch
);
  sample_t        smp_in [NCH];
  sample_t        held   [NCH];
  logic [NCH-1:0] slot_v;
  logic [NCH-1:0] lock;
  logic [NCH-1:0] done;
  logic           any;
  logic [CHW-1:0] idx;

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    assign smp_in[g].i = in_i[g*IQ_W +: IQ_W];
    assign smp_in[g].q = in_q[g*IQ_W +: IQ_W];

    iq_slot u_slot (
      .clk  (clk),
      .rst_n(rst_n),
      .in_v (in_valid[g]),
      .in_s (smp_in[g]),
      .lock (lock[g]),
      .done (done[g]),
      .vld  (slot_v[g]),
      .cur  (held[g])
    );
  end

  iq_prio_sel #(.NCH(NCH)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .pend_v(slot_v),
    .any   (any),
    .idx   (idx)
  );

  iq_out_seq #(.NCH(NCH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt8     (fmt8),
    .any      (any),
    .idx      (idx),
    .smp      (held),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_iq   (out_iq),
    .out_ch   (out_ch),
    .lock     (lock),
    .done     (done)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid); // R2
  AST_WRITE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_valid) |=> out_valid); // R1
endmodule

// File: tb/sim_iq_out_port.sv
module sim_iq_out_port;
  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fmt8 = 1'b0;
  logic [N-1:0]  in_valid = '0;
  logic [N*16-1:0] in_i = '0;
  logic [N*16-1:0] in_q = '0;
  logic          out_ready = 1'b0;
  logic          out_valid;
  logic [15:0]   out_data;
  logic          out_iq;
  logic [1:0]    out_ch;

  int vectors = 0;
  int miscompares = 0;

  iq_out_port u0 (
    .clk(clk), .rst_n(rst_n), .fmt8(fmt8), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_iq(out_iq), .out_ch(out_ch)
  );

  always #4 clk = ~clk;

  // behavioural reference state
  bit          mv [N];
  bit          mp [N];
  logic [15:0] mi [N], mq [N], pi [N], pq [N];
  bit          mph = 0;
  int          mhc = 0;

  function automatic bit m_req();
    bit r = mph;
    for (int c = 0; c < N; c++) r = r | mv[c];
    return r;
  endfunction

  function automatic int m_sel();
    if (mph) return mhc;
    for (int c = 0; c < N; c++) if (mv[c]) return c;
    return 0;
  endfunction

  function automatic logic [15:0] m_data();
    int s = m_sel();
    if (!m_req()) return 16'h0;
    if (mph) return mq[s];
    if (fmt8) return {mi[s][15:8], mq[s][15:8]};
    return mi[s];
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    int s; bit r, f, last, start, defer;
    if (!rst_n) begin
      for (int c = 0; c < N; c++) begin
        mv[c] = 0; mp[c] = 0; mi[c] = 0; mq[c] = 0; pi[c] = 0; pq[c] = 0;
      end
      mph = 0; mhc = 0;
    end else begin
      s = m_sel(); r = m_req();
      f = r && out_ready;
      last  = f && (mph || fmt8);
      start = f && !mph && !fmt8;
      for (int c = 0; c < N; c++) begin
        defer = r && (s == c) && ((mph && !f) || start);
        if (in_valid[c] && defer) begin
          mp[c] = 1; pi[c] = in_i[c*16 +: 16]; pq[c] = in_q[c*16 +: 16];
        end else begin
          if (in_valid[c]) begin
            mv[c] = 1; mi[c] = in_i[c*16 +: 16]; mq[c] = in_q[c*16 +: 16];
          end else if (last && s == c) begin
            if (mp[c]) begin mi[c] = pi[c]; mq[c] = pq[c]; end
            else mv[c] = 0;
          end
          if (last && s == c) mp[c] = 0;
        end
      end
      if (start) begin mph = 1; mhc = s; end
      else if (mph && f) mph = 0;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1", "model out_valid", 32'(out_valid), 32'(m_req()));
      chk(!m_req() ? "R11" : (mph ? "R3" : (fmt8 ? "R4" : "R3")),
          "model out_data", 32'(out_data), 32'(m_data()));
      chk(fmt8 ? "R5" : "R3", "model out_iq", 32'(out_iq), 32'(m_req() && !mph));
      chk("R6", "model out_ch", 32'(out_ch), m_req() ? 32'(m_sel()) : 32'd0);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    in_valid = '0;
  endtask

  task automatic push(int c, logic [15:0] i, logic [15:0] q);
    in_valid[c] = 1'b1;
    in_i[c*16 +: 16] = i;
    in_q[c*16 +: 16] = q;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    chk("R1", "reset valid", 32'(out_valid), 0);
    chk("R11", "reset data", 32'(out_data), 0);

    // R7 priority among simultaneous arrivals
    push(2, 16'h2222, 16'h2AAA); push(3, 16'h3333, 16'h3AAA); tick();
    chk("R1", "valid after write", 32'(out_valid), 1);
    chk("R7", "ch of 2,3", 32'(out_ch), 2);
    chk("R3", "I word", 32'(out_data), 32'h2222);
    push(1, 16'h1111, 16'h1AAA); tick();
    chk("R7", "ch1 preempts", 32'(out_ch), 1);
    repeat (3) tick();
    chk("R2", "stall valid", 32'(out_valid), 1);
    chk("R2", "stall data", 32'(out_data), 32'h1111);
    // R8 overwrite same channel
    push(1, 16'h1234, 16'h5678); tick();
    chk("R8", "overwrite I", 32'(out_data), 32'h1234);
    out_ready = 1'b1; tick();
    chk("R3", "Q word", 32'(out_data), 32'h5678);
    chk("R3", "Q iq low", 32'(out_iq), 0);
    out_ready = 1'b0;
    push(0, 16'h0A0A, 16'h0B0B); push(1, 16'h7777, 16'h7878); tick();
    chk("R7", "pair stays on ch1", 32'(out_ch), 1);
    chk("R9", "Q not replaced", 32'(out_data), 32'h5678);
    out_ready = 1'b1; tick();
    chk("R7", "ch0 next", 32'(out_ch), 0);
    chk("R7", "ch0 I", 32'(out_data), 32'h0A0A);
    tick(); tick();
    chk("R9", "deferred I", 32'(out_data), 32'h7777);
    tick();
    chk("R9", "deferred Q", 32'(out_data), 32'h7878);
    tick();
    chk("R8", "ch2 untouched", 32'(out_data), 32'h2222);
    tick(); tick(); tick(); tick();
    chk("R10", "drained", 32'(out_valid), 0);

    // packed format
    fmt8 = 1'b1; out_ready = 1'b0;
    push(0, 16'hAB12, 16'hCD34); push(2, 16'h1F00, 16'h2E00); tick();
    chk("R4", "packed word", 32'(out_data), 32'hABCD);
    chk("R4", "packed iq", 32'(out_iq), 1);
    out_ready = 1'b1; tick();
    chk("R5", "iq stays high", 32'(out_iq), 1);
    chk("R4", "packed ch2", 32'(out_data), 32'h1F2E);
    tick();
    chk("R5", "iq falls", 32'(out_iq), 0);
    chk("R10", "empty", 32'(out_valid), 0);
    out_ready = 1'b0;
    push(1, 16'h4400, 16'h5500); tick();
    chk("R4", "ch1 packed", 32'(out_data), 32'h4455);
    out_ready = 1'b1; push(1, 16'h6600, 16'h7700); tick();
    chk("R10", "refill on drain", 32'(out_valid), 1);
    chk("R10", "refill data", 32'(out_data), 32'h6677);
    tick();

    // random traffic, checked every cycle by the model
    for (int k = 0; k < 4000; k++) begin
      in_valid = 4'($urandom) & 4'($urandom);
      for (int c = 0; c < N; c++) begin
        in_i[c*16 +: 16] = 16'($urandom);
        in_q[c*16 +: 16] = 16'($urandom);
      end
      out_ready = ($urandom % 3) != 0;
      if (($urandom % 50) == 0) fmt8 = ~fmt8;
      tick();
    end
    out_ready = 1'b1;
    repeat (12) tick();
    chk("R1", "final drain", 32'(out_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule